// File: doc/BRIEF.md
# Video Keying Configuration Target (I2C, write-only)

This block is an I2C target, write-only, that sets up a video path with colour keying. It oversamples SCL and SDA on a system clock and answers only to one fixed 7-bit address. It holds three small control registers and shows their contents as decoded fields. These fields are the key mode, the chroma number coding, the key enable, the key polarity, the input format, the key delay and the key compare value. The block drives SDA only to acknowledge. It does this through an output-enable, so the pad stays open-drain and a low pull is the only drive.

A host writes in this order: START, address byte (R/W = 0), subaddress byte, one or more data bytes, STOP. The target acknowledges each byte. Each data byte after the first goes to the next subaddress. The block cannot be read, does not stretch the clock and does not arbitrate.

Top module: `vkey_cfg_target`

## Requirements
- R1: An address byte whose upper seven bits are 1011111 and whose LSB (R/W) is 0 is acknowledged: sda_oe is 1 for the whole ninth SCL pulse.
- R2: An address byte with any other upper bits, or with R/W = 1, is not acknowledged. All bytes after it, up to the next START, are neither acknowledged nor stored.
- R3: After an accepted address, the subaddress byte and every data byte are acknowledged.
- R4: A data byte at subaddress 0 sets key_mode = bits 7:5, chroma_bin = bit 4 (0 two's complement, 1 binary offset), key_en = bit 3, key_inv = bit 2 and fmt_sel = bits 1:0.
- R5: A data byte at subaddress 1 sets key_dly = bits 2:0. Bits 7:3 are discarded.
- R6: A data byte at subaddress 2 sets key_ref to the whole byte.
- R7: Each further data byte in a transfer goes to the previous subaddress plus 1. A data byte at subaddress 3 or higher is acknowledged but changes no field.
- R8: While rst_n is low, every field is 0 and sda_oe is 0.
- R9: A START, even in the middle of a byte, restarts address reception. A STOP returns the target to idle with SDA released. A transfer stopped before any data byte changes no field.
- R10: Fields change only on the SCL falling edge that ends the eighth bit of a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock. It must keep running for writes to take effect. |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | I2C clock line as seen at the pad |
| sda_in | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| key_mode | output | 3 | Key mode selection |
| chroma_bin | output | 1 | Chroma number coding, 1 = binary offset |
| key_en | output | 1 | Keying enable |
| key_inv | output | 1 | External key polarity |
| fmt_sel | output | 2 | Video input format |
| key_dly | output | 3 | Extra key delay in pixel clocks |
| key_ref | output | 8 | Colour key compare value |

## Verification
The assertions assume that SCL and SDA never change in the same sample and that each SCL level lasts much longer than the synchroniser depth plus one cycle. Under those conditions, edges seen on the synchronised lines keep their true order. They also assume that SDA changes while SCL is high only as a START or a STOP. The bench's bus model meets all of this. Every line change lands on a falling edge of clk, each SCL half period lasts eight clocks, and data moves only while SCL is low. Its ninth-bit release always takes place after the target has let go.

// File: rtl/vkey_cfg_target.sv
module vkey_cfg_target #(
  parameter logic [6:0] DEV_ADDR = 7'b1011111,
  parameter int         SYNC_LEN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic [2:0] key_mode,
  output logic       chroma_bin,
  output logic       key_en,
  output logic       key_inv,
  output logic [1:0] fmt_sel,
  output logic [2:0] key_dly,
  output logic [7:0] key_ref
);

  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);

  typedef enum logic [1:0] {IDLE, ADDR, SUB, DATA} st_t;

  logic [SYNC_LEN-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_LEN-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_LEN-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  assign scl_s = scl_sy[SYNC_LEN-1];
  assign sda_s = sda_sy[SYNC_LEN-1];

  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;

  st_t            st;
  logic           ack_ph;
  logic [CW-1:0]  cnt;
  logic [BITS-1:0] shreg, subp;
  logic [7:0]     r0, r2;
  logic [2:0]     r1;

  wire byte_done = scl_fall & ~ack_ph & (cnt == CW'(BITS)) & (st != IDLE);
  wire addr_ok   = (shreg[7:1] == DEV_ADDR) & ~shreg[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= IDLE;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      subp   <= '0;
      r0     <= '0;
      r1     <= '0;
      r2     <= '0;
    end else if (start_det) begin
      st     <= ADDR;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
      cnt    <= '0;
    end else if (stop_det) begin
      st     <= IDLE;
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
      cnt    <= '0;
    end else if (st != IDLE) begin
      if (scl_rise && !ack_ph && cnt != CW'(BITS)) begin
        shreg <= {shreg[BITS-2:0], sda_s};
        cnt   <= cnt + 1'b1;
      end
      if (byte_done) begin
        cnt <= '0;
        case (st)
          ADDR: if (addr_ok) begin
                  ack_ph <= 1'b1;
                  sda_oe <= 1'b1;
                end else st <= IDLE;
          SUB: begin
                 subp   <= shreg;
                 ack_ph <= 1'b1;
                 sda_oe <= 1'b1;
               end
          default: begin
                 case (subp)
                   8'd0: r0 <= shreg;
                   8'd1: r1 <= shreg[2:0];
                   8'd2: r2 <= shreg;
                   default: ;
                 endcase
                 subp   <= subp + 1'b1;
                 ack_ph <= 1'b1;
                 sda_oe <= 1'b1;
               end
        endcase
      end else if (scl_fall && ack_ph) begin
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
        if (st == ADDR) st <= SUB;
        else if (st == SUB) st <= DATA;
      end
    end

  assign {key_mode, chroma_bin, key_en, key_inv, fmt_sel} = r0;
  assign key_dly = r1;
  assign key_ref = r2;

  // R1
  ack_addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && st == ADDR) |-> ($past(shreg[7:1]) == DEV_ADDR && !$past(shreg[0])));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> !sda_oe);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == IDLE && !sda_oe));

  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ADDR && cnt == '0 && !ack_ph));

  // R10
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_fall |=> $stable({key_mode, chroma_bin, key_en, key_inv, fmt_sel, key_dly, key_ref}));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> ({key_mode, chroma_bin, key_en, key_inv, fmt_sel, key_dly, key_ref} == '0 && !sda_oe));

  // R3
  ack_pulse_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

endmodule

// File: tb/vkey_cfg_target_test.sv
`timescale 1ns/1ps
module vkey_cfg_target_test;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, chroma_bin, key_en, key_inv;
  logic [2:0] key_mode, key_dly;
  logic [1:0] fmt_sel;
  logic [7:0] key_ref;
  wire sda_bus = sda_m & ~sda_oe;

  int total = 0, bad = 0;
  logic [7:0] m0 = '0, m2 = '0;
  logic [2:0] m1 = '0;
  logic [18:0] exp_q[$];
  string tag_q[$];
  event txn_done;

  always #2.5 clk = ~clk;

  vkey_cfg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .key_mode(key_mode), .chroma_bin(chroma_bin), .key_en(key_en), .key_inv(key_inv),
    .fmt_sel(fmt_sel), .key_dly(key_dly), .key_ref(key_ref));

  wire [18:0] act_fields = {key_mode, chroma_bin, key_en, key_inv, fmt_sel, key_dly, key_ref};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(); scl_m = 1'b1; hw(); sda_m = 1'b0; hw(); scl_m = 1'b0; hw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(); scl_m = 1'b1; hw(); sda_m = 1'b1; hw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(); scl_m = 1'b1; hw(); scl_m = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(); scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = (sda_bus == 1'b0);
    repeat (H/2) @(negedge clk);
    scl_m = 1'b0; hw();
  endtask

  task automatic push_expect(input string tag);
    exp_q.push_back({m0, m1, m2});
    tag_q.push_back(tag);
    repeat (4) @(negedge clk);
    -> txn_done;
    repeat (2) @(negedge clk);
  endtask

  task automatic txn(input logic [7:0] a, input logic [7:0] s, input int nd,
                     input logic [7:0] d [4], input string tag);
    bit ack, acc;
    logic [7:0] sp;
    acc = (a[7:1] == 7'b1011111) && !a[0];
    sp = s;
    bus_start();
    send_byte(a, ack);
    check(ack == acc, acc ? "R1 address ack" : "R2 address nack", ack, acc);
    send_byte(s, ack);
    check(ack == acc, acc ? "R3 subaddress ack" : "R2 subaddress ignored", ack, acc);
    for (int k = 0; k < nd; k++) begin
      send_byte(d[k], ack);
      check(ack == acc, acc ? "R3 data ack" : "R2 data ignored", ack, acc);
      if (acc) begin
        if (sp == 8'd0) m0 = d[k];
        else if (sp == 8'd1) m1 = d[k][2:0];
        else if (sp == 8'd2) m2 = d[k];
        sp = sp + 1'b1;
      end
    end
    bus_stop();
    push_expect(tag);
  endtask

  initial begin
    forever begin
      @(txn_done);
      if (exp_q.size() == 0) check(1'b0, "scoreboard empty", 0, 1);
      else begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(act_fields == e, t, act_fields, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d [4];
    bit ack;
    repeat (3) @(negedge clk);
    check(act_fields == '0, "R8 reset fields", act_fields, 0);
    check(sda_oe == 1'b0, "R8 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    hw();

    d = '{8'hB6, 8'h00, 8'h00, 8'h00};
    txn(8'hBE, 8'd0, 1, d, "R4 reg0 fields");
    check(key_mode == 3'b101 && chroma_bin && !key_en && key_inv && fmt_sel == 2'b10,
          "R4 field split", act_fields, 19'h0);
    d = '{8'hFD, 8'h00, 8'h00, 8'h00};
    txn(8'hBE, 8'd1, 1, d, "R5 reg1 low bits");
    check(key_dly == 3'd5, "R5 key_dly", key_dly, 5);
    d = '{8'h3C, 8'h00, 8'h00, 8'h00};
    txn(8'hBE, 8'd2, 1, d, "R6 reg2 value");

    d = '{8'h48, 8'h07, 8'hA5, 8'h11};
    txn(8'hBE, 8'd0, 4, d, "R7 auto increment");
    d = '{8'h99, 8'h00, 8'h00, 8'h00};
    txn(8'hBE, 8'd5, 1, d, "R7 high subaddress");

    d = '{8'hFF, 8'h00, 8'h00, 8'h00};
    txn(8'hBC, 8'd0, 1, d, "R2 wrong address");
    txn(8'hBF, 8'd2, 1, d, "R2 read request");

    bus_start();
    send_bits(8'h55, 3);
    d = '{8'h81, 8'h00, 8'h00, 8'h00};
    txn(8'hBE, 8'd2, 1, d, "R9 start mid byte");

    bus_start();
    send_byte(8'hBE, ack);
    check(ack, "R1 address ack", ack, 1);
    send_byte(8'h00, ack);
    check(ack, "R3 subaddress ack", ack, 1);
    bus_stop();
    repeat (4) @(negedge clk);
    check(sda_oe == 1'b0, "R9 stop releases", sda_oe, 0);
    push_expect("R9 stop before data");

    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(act_fields == '0, "R8 mid-run reset", act_fields, 0);
    check(sda_oe == 1'b0, "R8 mid-run sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    m0 = '0; m1 = '0; m2 = '0;
    hw();
    d = '{8'h5A, 8'h00, 8'h00, 8'h00};
    txn(8'hBE, 8'd2, 1, d, "R8 write after reset");

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule